// File: doc/BRIEF.md
# Timed Transmit Scheduler Table

This block decides when each of a set of preloaded 32-bit words goes out on a serial avionics transmitter. A command table and a data table share one index space. Each command entry chooses a clock source and carries a delay. Master entries count ticks of their chosen source and become pending when the count reaches the delay. The slave entries that follow a master in the table become pending together with it. A recyclable master then starts a new delay. A non-recyclable master fires once.

A received-label cross-trigger can also make an enabled master and its slaves pending. This works even when the master's prescaler is stopped. Pending words are offered one at a time, lowest index first, to a downstream arbiter that retires each one with an acknowledge. Per-entry status shows three things: whether the entry is pending, whether it has been sent at least once, and whether it was re-marked before its previous request was served. The last case also raises a one-cycle overrun interrupt.

Three time sources are built in: a base tick every `TB_DIV` clocks, standing for 100 µs, and two 16-bit prescalers that each have their own enable. Software writes commands and data, and reads status back, through a simple single-cycle register port.

Top module: `sched_tx_table`

## Requirements
- R1: With cfg_sel_i=0 the register port addresses the command table, and with cfg_sel_i=1 it addresses the data table. A command read returns: sent-once flag at bit 24, pending flag at bit 23, overrun flag at bit 22, clock source at bits 21:20, master at bit 17, recyclable at bit 16, and delay at bits 15:0. Every other bit reads 0, whatever was written to it.
- R2: Clock source codes: 00 means the entry is disabled and never becomes pending; 01 means the base tick; 10 means prescaler 0; 11 means prescaler 1.
- R3: A master's counter advances on each tick of its source. The master becomes pending on the tick where the count reaches the delay, and a delay of 0 behaves as 1. With immediate acknowledges, a recyclable master is offered every delay × source-period clocks.
- R4: After a non-recyclable master has fired on its timer, it does not fire on its timer again until its command is rewritten.
- R5: When a master becomes pending, every following entry with master=0, up to the next master, becomes pending in the same cycle. Slaves with source 00 are skipped.
- R6: tx_valid_o is high while any entry is pending. tx_idx_o is the lowest pending index and tx_word_o is the data word at that index. The offer holds until tx_ack_i retires it, and the acknowledge clears that entry's pending flag.
- R7: The sent-once flag is set by the first acknowledge of the entry and then stays set.
- R8: When an entry in a recyclable group is marked while its pending flag is still set, the overrun flag sets and stays set. ovr_irq_o then pulses for one cycle, the cycle after the marking edge.
- R9: Writing a command clears that entry's pending, sent-once and overrun flags and its delay counter, even when the written value equals the old one.
- R10: A cross-trigger marks the entry at xtrig_idx_i, and its slaves, on the next edge, provided that entry is a master with a source other than 00. A cross-trigger at a slave or at a disabled entry has no effect.
- R11: Prescaler n, while enabled, ticks once every div+1 clocks. While disabled it does not tick, so its entries stay paused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 1 | Table select: 0 command, 1 data |
| cfg_addr_i | input | IDX_W | Entry index |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Read data (combinational) |
| ps_en_i | input | 2 | Prescaler enables |
| ps0_div_i | input | PS_W | Prescaler 0 divisor minus one |
| ps1_div_i | input | PS_W | Prescaler 1 divisor minus one |
| xtrig_valid_i | input | 1 | Cross-trigger strobe |
| xtrig_idx_i | input | IDX_W | Cross-trigger entry index |
| tx_valid_o | output | 1 | A word is offered |
| tx_idx_o | output | IDX_W | Index of the offered word |
| tx_word_o | output | 32 | Offered data word |
| tx_ack_i | input | 1 | Offered word accepted |
| ovr_irq_o | output | 1 | Overrun interrupt pulse |

## Verification
The bench measures the interval between successive offers of a recyclable master under each clock source, including a zero delay. A counter that is off by one, or that ignores the prescaler divisor, shows up there as a wrong cycle count. It checks that a master's group stops at the next master and skips disabled slaves, and that several pending entries drain in index order rather than in marking order. A design that chained groups wrongly, or that queued entries first-come first-served, would fail those checks. It also re-marks a recyclable master whose request is still pending, then rewrites the same command value. A design that missed the overrun, failed to pulse the interrupt, or cleared status only when the value changed would be caught. Finally, it cross-triggers slaves and disabled masters, which must produce no offer.

// File: rtl/sched_pkg.sv
package sched_pkg;
  typedef enum logic [1:0] {
    SRC_OFF  = 2'b00,
    SRC_BASE = 2'b01,
    SRC_PS0  = 2'b10,
    SRC_PS1  = 2'b11
  } clk_src_e;

  typedef struct packed {
    clk_src_e    src;
    logic        master;
    logic        recycle;
    logic [15:0] delay;
  } cmd_t;

  localparam int unsigned SRC_LSB = 20;
  localparam int unsigned MA_BIT  = 17;
  localparam int unsigned RC_BIT  = 16;
endpackage

// File: rtl/sched_timebase.sv
module sched_timebase #(
  parameter int unsigned TB_DIV = 6600,
  parameter int unsigned PS_W   = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [1:0]      ps_en_i,
  input  logic [PS_W-1:0] ps0_div_i,
  input  logic [PS_W-1:0] ps1_div_i,
  output logic [2:0]      tick_o
);
  localparam int unsigned TB_W = (TB_DIV > 1) ? $clog2(TB_DIV) : 1;

  logic [TB_W-1:0] base_cnt_q;
  logic            base_hit;

  assign base_hit  = (base_cnt_q == TB_W'(TB_DIV - 1));
  assign tick_o[0] = base_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       base_cnt_q <= '0;
    else if (base_hit) base_cnt_q <= '0;
    else               base_cnt_q <= base_cnt_q + 1'b1;
  end

  logic [PS_W-1:0] div_w [2];
  assign div_w[0] = ps0_div_i;
  assign div_w[1] = ps1_div_i;

  for (genvar p = 0; p < 2; p++) begin : g_ps
    logic [PS_W-1:0] cnt_q;
    logic            hit;

    assign hit         = ps_en_i[p] && (cnt_q == div_w[p]);
    assign tick_o[p+1] = hit;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 cnt_q <= '0;
      else if (!ps_en_i[p] || hit) cnt_q <= '0;
      else                         cnt_q <= cnt_q + 1'b1;
    end

    // R11
    ps_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ps_en_i[p] && div_w[p] != '0) |=> !tick_o[p+1]);
  end
endmodule

// File: rtl/sched_entry.sv
module sched_entry
  import sched_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  cmd_t        wr_cmd_i,
  input  logic [2:0]  tick_i,
  input  logic        mark_i,
  input  logic        grp_rc_i,
  input  logic        ack_i,
  output logic        ma_o,
  output logic        rc_o,
  output logic        en_o,
  output logic        fire_o,
  output logic        me_o,
  output logic        ovr_o,
  output logic [31:0] stat_o
);
  cmd_t        cmd_q;
  logic [15:0] cnt_q;
  logic        spent_q, me_q, eco_q, eo_q;
  logic        sel_tick, expire, marked;

  always_comb begin
    case (cmd_q.src)
      SRC_BASE: sel_tick = tick_i[0];
      SRC_PS0:  sel_tick = tick_i[1];
      SRC_PS1:  sel_tick = tick_i[2];
      default:  sel_tick = 1'b0;
    endcase
  end

  assign en_o   = (cmd_q.src != SRC_OFF);
  assign ma_o   = cmd_q.master;
  assign rc_o   = cmd_q.recycle;
  assign expire = ({1'b0, cnt_q} + 17'd1) >= {1'b0, cmd_q.delay};
  assign fire_o = cmd_q.master && !spent_q && sel_tick && expire;
  assign marked = mark_i && en_o;
  assign ovr_o  = marked && me_q && !ack_i && grp_rc_i && !wr_i;
  assign me_o   = me_q;
  assign stat_o = {7'b0, eco_q, me_q, eo_q, cmd_q.src, 2'b0,
                   cmd_q.master, cmd_q.recycle, cmd_q.delay};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q   <= '0;
      cnt_q   <= '0;
      spent_q <= 1'b0;
      me_q    <= 1'b0;
      eco_q   <= 1'b0;
      eo_q    <= 1'b0;
    end else if (wr_i) begin
      cmd_q   <= wr_cmd_i;
      cnt_q   <= '0;
      spent_q <= 1'b0;
      me_q    <= 1'b0;
      eco_q   <= 1'b0;
      eo_q    <= 1'b0;
    end else begin
      if (cmd_q.master && !spent_q && sel_tick) begin
        if (expire) begin
          cnt_q   <= '0;
          spent_q <= !cmd_q.recycle;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
      if (marked)     me_q <= 1'b1;
      else if (ack_i) me_q <= 1'b0;
      if (ack_i) eco_q <= 1'b1;
      if (ovr_o) eo_q  <= 1'b1;
    end
  end

  // R7
  eco_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(eco_q) |-> $past(ack_i) && !$past(wr_i));

  // R8
  eo_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eo_q && !wr_i) |=> eo_q);

  // R9
  wr_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (!eco_q && !eo_q && !me_q));

  // R4
  once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spent_q && !wr_i) |=> !fire_o);
endmodule

// File: rtl/sched_pick.sv
module sched_pick #(
  parameter int unsigned N     = 256,
  parameter int unsigned IDX_W = 8
) (
  input  logic [N-1:0]     req_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);
  assign valid_o = |req_i;

  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/sched_tx_table.sv
module sched_tx_table
  import sched_pkg::*;
#(
  parameter int unsigned N_ENT  = 256,
  parameter int unsigned TB_DIV = 6600,
  parameter int unsigned PS_W   = 16,
  localparam int unsigned IDX_W = $clog2(N_ENT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic             cfg_sel_i,
  input  logic [IDX_W-1:0] cfg_addr_i,
  input  logic [31:0]      cfg_wdata_i,
  output logic [31:0]      cfg_rdata_o,
  input  logic [1:0]       ps_en_i,
  input  logic [PS_W-1:0]  ps0_div_i,
  input  logic [PS_W-1:0]  ps1_div_i,
  input  logic             xtrig_valid_i,
  input  logic [IDX_W-1:0] xtrig_idx_i,
  output logic             tx_valid_o,
  output logic [IDX_W-1:0] tx_idx_o,
  output logic [31:0]      tx_word_o,
  input  logic             tx_ack_i,
  output logic             ovr_irq_o
);
  logic [2:0]       tick_w;
  logic [N_ENT-1:0] mark_w, rc_w, fire_w, me_w, ovr_w, ma_w, rcb_w, en_w;
  logic [31:0]      stat_w [N_ENT];
  logic [31:0]      data_q [N_ENT];
  logic             ovr_q;
  cmd_t             wr_cmd;

  assign wr_cmd = '{src:     clk_src_e'(cfg_wdata_i[SRC_LSB+1:SRC_LSB]),
                    master:  cfg_wdata_i[MA_BIT],
                    recycle: cfg_wdata_i[RC_BIT],
                    delay:   cfg_wdata_i[15:0]};

  sched_timebase #(.TB_DIV(TB_DIV), .PS_W(PS_W)) u_tb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ps_en_i   (ps_en_i),
    .ps0_div_i (ps0_div_i),
    .ps1_div_i (ps1_div_i),
    .tick_o    (tick_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_ENT; i++) data_q[i] <= '0;
    end else if (cfg_we_i && cfg_sel_i) begin
      data_q[cfg_addr_i] <= cfg_wdata_i;
    end
  end

  for (genvar i = 0; i < N_ENT; i++) begin : g_ent
    logic wr, ack, xt;
    assign wr  = cfg_we_i && !cfg_sel_i && (cfg_addr_i == IDX_W'(i));
    assign ack = tx_ack_i && tx_valid_o && (tx_idx_o == IDX_W'(i));
    assign xt  = xtrig_valid_i && (xtrig_idx_i == IDX_W'(i)) && en_w[i];

    sched_entry u_ent (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_i     (wr),
      .wr_cmd_i (wr_cmd),
      .tick_i   (tick_w),
      .mark_i   (mark_w[i]),
      .grp_rc_i (rc_w[i]),
      .ack_i    (ack),
      .ma_o     (ma_w[i]),
      .rc_o     (rcb_w[i]),
      .en_o     (en_w[i]),
      .fire_o   (fire_w[i]),
      .me_o     (me_w[i]),
      .ovr_o    (ovr_w[i]),
      .stat_o   (stat_w[i])
    );

    // group membership: a slave inherits from the nearest master above it
    if (i == 0) begin : g_head
      assign mark_w[i] = ma_w[i] && (fire_w[i] || xt);
      assign rc_w[i]   = ma_w[i] && rcb_w[i];
    end else begin : g_link
      assign mark_w[i] = ma_w[i] ? (fire_w[i] || xt) : mark_w[i-1];
      assign rc_w[i]   = ma_w[i] ? rcb_w[i] : rc_w[i-1];
    end
  end

  sched_pick #(.N(N_ENT), .IDX_W(IDX_W)) u_pick (
    .req_i   (me_w),
    .valid_o (tx_valid_o),
    .idx_o   (tx_idx_o)
  );

  assign tx_word_o   = data_q[tx_idx_o];
  assign cfg_rdata_o = cfg_sel_i ? data_q[cfg_addr_i] : stat_w[cfg_addr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ovr_q <= 1'b0;
    else         ovr_q <= |ovr_w;
  end
  assign ovr_irq_o = ovr_q;

  // R6
  offer_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ack_i && !cfg_we_i) |=> tx_valid_o);

  // R6
  offer_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ack_i && !cfg_we_i) |=> (tx_idx_o <= $past(tx_idx_o)));
endmodule

// File: tb/tb_sched_tx_table.sv
`timescale 1ns/1ps
module tb_sched_tx_table;
  localparam int unsigned N_ENT  = 8;
  localparam int unsigned TB_DIV = 5;
  localparam int unsigned PS_W   = 8;

  typedef struct packed {
    logic [1:0]  src;
    logic [15:0] td;
    logic [7:0]  div;
    logic [15:0] period;
  } vec_t;

  localparam vec_t VEC [5] = '{
    '{2'd1, 16'd3, 8'd0, 16'd15},
    '{2'd1, 16'd1, 8'd0, 16'd5},
    '{2'd1, 16'd0, 8'd0, 16'd5},
    '{2'd2, 16'd4, 8'd2, 16'd12},
    '{2'd3, 16'd2, 8'd6, 16'd14}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic [1:0]  ps_en = '0;
  logic [7:0]  ps0_div = '0, ps1_div = '0;
  logic        xt_v = 1'b0;
  logic [2:0]  xt_idx = '0;
  logic        tx_valid, tx_ack = 1'b0, ovr_irq;
  logic [2:0]  tx_idx;
  logic [31:0] tx_word;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sched_tx_table #(.N_ENT(N_ENT), .TB_DIV(TB_DIV), .PS_W(PS_W)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .ps_en_i(ps_en), .ps0_div_i(ps0_div), .ps1_div_i(ps1_div),
    .xtrig_valid_i(xt_v), .xtrig_idx_i(xt_idx),
    .tx_valid_o(tx_valid), .tx_idx_o(tx_idx), .tx_word_o(tx_word),
    .tx_ack_i(tx_ack), .ovr_irq_o(ovr_irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input bit sel, input int a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_addr = 3'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input bit sel, input int a, output logic [31:0] d);
    cfg_sel = sel; cfg_addr = 3'(a);
    #0.5;
    d = cfg_rdata;
  endtask

  task automatic wait_valid(input int lim, output int n);
    n = 0;
    while (!tx_valid && n < lim) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic ack();
    tx_ack = 1'b1;
    @(negedge clk);
    tx_ack = 1'b0;
  endtask

  task automatic xtrig(input int idx);
    xt_v = 1'b1; xt_idx = 3'(idx);
    @(negedge clk);
    xt_v = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=expired expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int n;
    int seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    chk(!tx_valid, "R6 reset valid", 32'(tx_valid), 0);
    chk(!ovr_irq, "R8 reset irq", 32'(ovr_irq), 0);
    rd(0, 0, r); chk(r == 0, "R1 reset cmd", r, 0);
    rd(1, 3, r); chk(r == 0, "R1 reset data", r, 0);

    // vector table: recyclable master on entry 0, measure offer period
    for (int v = 0; v < 5; v++) begin
      logic [31:0] cw;
      string tag;
      tag = (VEC[v].src == 2'd1) ? "R3 period" : "R11 period";
      cw = (32'(VEC[v].src) << 20) | 32'h0003_0000 | 32'(VEC[v].td);
      ps_en = 2'b11; ps0_div = VEC[v].div; ps1_div = VEC[v].div;
      wr(0, 0, cw);
      wait_valid(300, n);
      chk(tx_valid && tx_idx == 0, "R3 first fire", 32'(tx_idx), 0);
      ack();
      n = 1;
      while (!tx_valid && n < 400) begin
        @(negedge clk);
        n++;
      end
      chk(n == int'(VEC[v].period), tag, 32'(n), 32'(VEC[v].period));
      ack();
      wr(0, 0, 32'h0);
    end
    ps_en = 2'b00;

    // data readback and group setup
    wr(1, 2, 32'hA5A5_0102);
    wr(1, 3, 32'hB6B6_0304);
    wr(1, 5, 32'hC7C7_0506);
    wr(1, 6, 32'hD8D8_0708);
    rd(1, 3, r); chk(r == 32'hB6B6_0304, "R1 data readback", r, 32'hB6B6_0304);
    wr(0, 3, 32'h0010_0000);
    wr(0, 4, 32'h0000_0000);
    wr(0, 5, 32'h0010_0000);
    wr(0, 6, 32'h0022_0003);
    wr(0, 7, 32'h0002_0000);
    wr(0, 2, 32'h0012_0002);

    wait_valid(200, n);
    chk(tx_valid && tx_idx == 2, "R3 master fire", 32'(tx_idx), 2);
    rd(0, 5, r); chk(r[23], "R5 slave marked with master", r, 32'h0090_0000);
    rd(0, 4, r); chk(!r[23], "R5 disabled slave skipped", r, 0);
    chk(tx_word == 32'hA5A5_0102, "R6 word at idx 2", tx_word, 32'hA5A5_0102);
    ack();
    chk(tx_valid && tx_idx == 3 && tx_word == 32'hB6B6_0304, "R5 slave 3", {29'b0, tx_idx}, 3);
    ack();
    chk(tx_valid && tx_idx == 5 && tx_word == 32'hC7C7_0506, "R5 slave 5", {29'b0, tx_idx}, 5);
    ack();
    chk(!tx_valid, "R6 drained", 32'(tx_valid), 0);
    rd(0, 2, r); chk(r == 32'h0112_0002, "R7 sent-once set", r, 32'h0112_0002);

    seen = 0;
    for (int c = 0; c < 60; c++) begin
      @(negedge clk);
      if (tx_valid) seen++;
    end
    chk(seen == 0, "R4 no refire / R11 paused", 32'(seen), 0);

    // cross-triggers
    xtrig(6);
    chk(tx_valid && tx_idx == 6 && tx_word == 32'hD8D8_0708, "R10 xtrig paused master", {29'b0, tx_idx}, 6);
    xtrig(2);
    chk(tx_valid && tx_idx == 2, "R6 ascending order", {29'b0, tx_idx}, 2);
    ack();
    chk(tx_idx == 3, "R10 xtrig slave 3", {29'b0, tx_idx}, 3);
    ack();
    chk(tx_idx == 5, "R10 xtrig slave 5", {29'b0, tx_idx}, 5);
    ack();
    chk(tx_valid && tx_idx == 6, "R6 then idx 6", {29'b0, tx_idx}, 6);
    ack();
    chk(!tx_valid, "R6 empty", 32'(tx_valid), 0);
    xtrig(7);
    chk(!tx_valid, "R2 R10 disabled master ignored", 32'(tx_valid), 0);
    xtrig(4);
    chk(!tx_valid, "R10 disabled slave ignored", 32'(tx_valid), 0);
    xtrig(3);
    chk(!tx_valid, "R10 slave index ignored", 32'(tx_valid), 0);

    // overrun on a recyclable master, then same-value rewrite
    wr(0, 0, 32'h0033_0005);
    xtrig(0);
    chk(tx_valid && tx_idx == 0, "R10 xtrig entry 0", {29'b0, tx_idx}, 0);
    ack();
    xtrig(0);
    chk(!ovr_irq, "R8 no overrun on first mark", 32'(ovr_irq), 0);
    xtrig(0);
    chk(ovr_irq, "R8 irq pulse", 32'(ovr_irq), 1);
    @(negedge clk);
    chk(!ovr_irq, "R8 irq one cycle", 32'(ovr_irq), 0);
    rd(0, 0, r); chk(r == 32'h01F3_0005, "R8 status flags", r, 32'h01F3_0005);
    wr(0, 0, 32'h0033_0005);
    rd(0, 0, r); chk(r == 32'h0033_0005, "R9 same-value write clears", r, 32'h0033_0005);
    chk(!tx_valid, "R9 pending cleared", 32'(tx_valid), 0);

    // reserved bits
    wr(0, 7, 32'hFFFF_FFFF);
    rd(0, 7, r); chk(r == 32'h0033_FFFF, "R1 reserved read zero", r, 32'h0033_FFFF);
    wr(0, 7, 32'h0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule